// File: doc/BRIEF.md
# Add-Only Memory Read Sequencer

This block is the read-side command controller for a write-once memory made of 256 pages of 32 data bytes, plus a status memory that is read in 8-byte pages. It takes three bytes from the bus side, in this order: a command byte, the low address byte and the high address byte. It then fetches bytes through a synchronous memory port. Each byte goes out one bit per read-slot request, least significant bit first.

Three read commands are handled. A plain read streams data to the top of the data field and ends with one CRC. A status read adds a CRC at every 8-byte page boundary. An extended read first sends the redirection byte for each 32-byte page and a CRC. It then sends that page's data and a CRC at the page end. Unknown commands make the block answer all ones. Reset is the only way back to the command phase.

Top module: `addonly_read_seq`

## Requirements
- R1: While reset is held and right after it, `slot_ready`, `bit_valid` and `mem_req` are low. The first three `in_valid` bytes are taken as command, address bits 7:0 and address bits 15:8.
- R2: A `slot_req` seen while `slot_ready` is high yields `bit_valid` with its bit on the next clock cycle. A `slot_req` seen while `slot_ready` is low is dropped and consumes nothing. Bytes go out least significant bit first.
- R3: Every CRC uses the polynomial x^16+x^15+x^2+1 in reflected form (0xA001), starts from zero and takes each byte LSB first. It is sent inverted, low byte first.
- R4: Command F0h masks the address to 13 bits and streams data bytes up to 1FFFh. It then sends one CRC over the command, both address bytes as received, and every data byte sent.
- R5: After the final CRC of any command, every read slot returns 1 and no memory request is issued until reset.
- R6: Command AAh streams status bytes from the 16-bit address and sends a CRC after each byte whose address has low bits 111b. The first CRC covers command, address and data. Each later CRC restarts from zero and covers that page's bytes only. The CRC after a page ending at 1FFh or above is the final one.
- R7: Status addresses 60h–FFh and 200h and above read as FFh, and the block issues no memory request for them.
- R8: Command A5h masks the address to 13 bits and first sends the redirection byte for its page, taken from status address 100h + address bits 12:5. Next comes a CRC over command, address and that byte. Then come the data bytes up to the end of the 32-byte page.
- R9: In an A5h read, each end-of-page CRC restarts from zero and covers only the data sent from that page. It is followed by the next page's redirection byte, a CRC of that byte alone, and that page's data from its first byte. The CRC after page 255 is the final one.
- R10: Any other command byte makes every read slot return 1, with no memory request, until reset.
- R11: `in_valid` bytes that arrive after the address phase are ignored.
- R12: `mem_req` lasts one cycle, and `mem_rdata` is taken on the following cycle. `mem_status` is 1 for status fetches and 0 for data fetches. Exactly one request is made per fetched byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; ends any command |
| in_valid | input | 1 | A byte from the bus side is present |
| in_byte | input | 8 | Command or address byte |
| slot_req | input | 1 | Read-slot request |
| slot_ready | output | 1 | A read slot can be served this cycle |
| bit_valid | output | 1 | `bit_out` carries the answer to a slot |
| bit_out | output | 1 | Serialized read bit |
| mem_req | output | 1 | One-cycle memory fetch strobe |
| mem_status | output | 1 | Fetch targets status memory |
| mem_addr | output | 13 | Fetch byte address |
| mem_rdata | input | 8 | Fetched byte, valid the cycle after `mem_req` |

## Verification
Each bit answer arrives exactly one cycle after the accepted slot request. The bench raises a request on a falling edge and reads `bit_valid` and `bit_out` on the next falling edge, so every bit is sampled half a cycle after the edge that produced it. A memory fetch returns data one cycle after `mem_req`, and the bench's memory model presents data only in that cycle, so a fetch sampled in the wrong cycle shows up as a wrong byte. The bench does not predict when a fetch ends; it waits on `slot_ready` between bytes and then compares whole bytes, CRCs and trailing ones against its own byte-level model of each command.

// File: rtl/addonly_read_seq.sv
module addonly_read_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic        slot_req,
  output logic        slot_ready,
  output logic        bit_valid,
  output logic        bit_out,
  output logic        mem_req,
  output logic        mem_status,
  output logic [12:0] mem_addr,
  input  logic [7:0]  mem_rdata
);

  localparam logic [7:0]  OP_PLAIN  = 8'hF0;
  localparam logic [7:0]  OP_STAT   = 8'hAA;
  localparam logic [7:0]  OP_EXT    = 8'hA5;
  localparam logic [16:0] DATA_END  = 17'h02000;
  localparam logic [16:0] STAT_END  = 17'h00200;
  localparam logic [16:0] GAP_LO    = 17'h00060;
  localparam logic [16:0] REDIR_LO  = 17'h00100;
  localparam logic [15:0] CRC_POLY  = 16'hA001;

  typedef enum logic [2:0] {S_CMD, S_AL, S_AH, S_REQ, S_CAP, S_SHIFT, S_DONE, S_IGN} st_t;
  typedef enum logic [1:0] {M_PLAIN, M_STAT, M_EXT} mode_t;
  typedef enum logic [2:0] {K_DATA, K_STAT, K_REDIR, K_CRCL, K_CRCH, K_ONES} kind_t;

  st_t         st;
  mode_t       mode;
  kind_t       kind, nk, lk;
  logic [16:0] ptr, fa;
  logic [15:0] crc;
  logic [7:0]  sh, fetched;
  logic [2:0]  bcnt;
  logic        rphase, take, stat_impl, do_load;

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign slot_ready = (st == S_SHIFT) || (st == S_DONE) || (st == S_IGN);
  assign take       = slot_req && slot_ready;

  assign fa        = (kind == K_REDIR) ? (REDIR_LO | {9'd0, ptr[12:5]}) : ptr;
  assign stat_impl = (fa < GAP_LO) || ((fa >= REDIR_LO) && (fa < STAT_END));
  assign mem_status = (kind != K_DATA);
  assign mem_addr   = (kind == K_DATA) ? ptr[12:0] : fa[12:0];
  assign mem_req    = (st == S_REQ) && ((kind == K_DATA) || stat_impl);
  assign fetched    = ((kind != K_DATA) && !stat_impl) ? 8'hFF : mem_rdata;

  always_comb begin
    nk = K_ONES;
    case (kind)
      K_DATA:  if (mode == M_EXT) nk = (ptr[4:0] == 5'd0) ? K_CRCL : K_DATA;
               else               nk = (ptr == DATA_END) ? K_CRCL : K_DATA;
      K_STAT:  nk = (ptr[2:0] == 3'd0) ? K_CRCL : K_STAT;
      K_REDIR: nk = K_CRCL;
      K_CRCL:  nk = K_CRCH;
      K_CRCH:  case (mode)
                 M_STAT:  nk = (ptr >= STAT_END) ? K_ONES : K_STAT;
                 M_EXT:   nk = rphase ? K_DATA : ((ptr == DATA_END) ? K_ONES : K_REDIR);
                 default: nk = K_ONES;
               endcase
      default: nk = K_ONES;
    endcase
  end

  always_comb begin
    lk = nk;
    if (st == S_AH)
      case (mode)
        M_PLAIN: lk = K_DATA;
        M_STAT:  lk = K_STAT;
        default: lk = K_REDIR;
      endcase
  end

  assign do_load = ((st == S_AH) && in_valid) || ((st == S_SHIFT) && take && (bcnt == 3'd7));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_CMD;
      mode      <= M_PLAIN;
      kind      <= K_ONES;
      ptr       <= '0;
      crc       <= '0;
      sh        <= '0;
      bcnt      <= '0;
      rphase    <= 1'b0;
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
    end else begin
      bit_valid <= take;
      if (take) bit_out <= (st == S_SHIFT) ? sh[0] : 1'b1;

      case (st)
        S_CMD: if (in_valid) begin
          crc <= crc_byte(16'h0000, in_byte);
          st  <= S_AL;
          case (in_byte)
            OP_PLAIN: mode <= M_PLAIN;
            OP_STAT:  mode <= M_STAT;
            OP_EXT:   mode <= M_EXT;
            default:  st   <= S_IGN;
          endcase
        end
        S_AL: if (in_valid) begin
          ptr <= {9'd0, in_byte};
          crc <= crc_byte(crc, in_byte);
          st  <= S_AH;
        end
        S_AH: if (in_valid) begin
          crc <= crc_byte(crc, in_byte);
          if (mode == M_STAT) ptr <= {1'b0, in_byte, ptr[7:0]};
          else                ptr <= {4'd0, in_byte[4:0], ptr[7:0]};
        end
        S_REQ: st <= S_CAP;
        S_CAP: begin
          sh     <= fetched;
          crc    <= crc_byte(crc, fetched);
          bcnt   <= 3'd0;
          rphase <= (kind == K_REDIR);
          if (kind != K_REDIR) ptr <= ptr + 17'd1;
          st     <= S_SHIFT;
        end
        S_SHIFT: if (take) begin
          sh   <= sh >> 1;
          bcnt <= bcnt + 3'd1;
        end
        default: ;
      endcase

      if (do_load) begin
        kind <= lk;
        case (lk)
          K_DATA, K_STAT, K_REDIR: st <= S_REQ;
          K_CRCL: begin
            sh <= ~crc[7:0];
            st <= S_SHIFT;
          end
          K_CRCH: begin
            sh  <= ~crc[15:8];
            crc <= 16'h0000;
            st  <= S_SHIFT;
          end
          default: st <= S_DONE;
        endcase
      end
    end
  end

  // R12
  mem_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R7
  stat_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_status) |-> ((mem_addr < 13'h060) || ((mem_addr >= 13'h100) && (mem_addr < 13'h200))));

  // R2
  bit_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(slot_req && slot_ready));

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE) |=> ((st == S_DONE) && !mem_req));

  // R5
  done_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && $past(st == S_DONE)) |-> bit_out);

  // R10
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |=> ((st == S_IGN) && !mem_req));

  // R12
  plain_no_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && (mode == M_PLAIN)) |-> !mem_status);

endmodule

// File: tb/sim_addonly_read_seq.sv
`timescale 1ns/1ps
module sim_addonly_read_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        slot_req = 1'b0;
  logic        slot_ready, bit_valid, bit_out;
  logic        mem_req, mem_status;
  logic [12:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0;
  int fails = 0;
  int nreq = 0;
  int nstat = 0;
  int badreq = 0;
  logic [7:0] expb [0:255];

  always #2.5 clk = ~clk;

  addonly_read_seq u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .slot_req(slot_req), .slot_ready(slot_ready), .bit_valid(bit_valid), .bit_out(bit_out),
    .mem_req(mem_req), .mem_status(mem_status), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] dmem(input int a);
    return 8'(a * 13 + (a >> 8));
  endfunction

  function automatic bit simpl(input int a);
    return (a < 'h60) || (a >= 'h100 && a < 'h200);
  endfunction

  function automatic logic [7:0] smem(input int a);
    if (a < 'h20) return 8'hF0 ^ 8'(a);
    if (a < 'h60) return 8'(a * 3 + 1);
    if (a >= 'h100 && a < 'h200) begin
      if (a == 'h105) return 8'hF6;
      if (a == 'h1FF) return 8'hFD;
      return 8'hFF;
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] svis(input int a);
    return simpl(a) ? smem(a) : 8'hFF;
  endfunction

  function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  always @(posedge clk) begin
    mem_rdata <= 8'h00;
    if (mem_req) begin
      nreq = nreq + 1;
      if (mem_status) begin
        nstat = nstat + 1;
        if (!simpl(int'(mem_addr))) badreq = badreq + 1;
        mem_rdata <= smem(int'(mem_addr));
      end else begin
        mem_rdata <= dmem(int'(mem_addr));
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: got 150000 cycles expected completion");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  task automatic build(input logic [7:0] cmd, input logic [15:0] a);
    int n = 0;
    int p;
    logic [15:0] c;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) expb[i] = 8'hFF;
    c = bcrc(bcrc(bcrc(16'h0, cmd), a[7:0]), a[15:8]);
    if (cmd == 8'hF0) begin
      for (p = int'(a) & 'h1FFF; p < 'h2000; p++) begin
        b = dmem(p); c = bcrc(c, b);
        if (n < 256) expb[n] = b; n++;
      end
      if (n < 255) begin expb[n] = ~c[7:0]; expb[n+1] = ~c[15:8]; end
    end else if (cmd == 8'hAA) begin
      p = int'(a);
      while (1) begin
        b = svis(p); c = bcrc(c, b);
        if (n < 256) expb[n] = b; n++;
        p++;
        if (p % 8 == 0) begin
          if (n < 255) begin expb[n] = ~c[7:0]; expb[n+1] = ~c[15:8]; end
          n += 2; c = 16'h0;
          if (p >= 'h200) break;
        end
      end
    end else if (cmd == 8'hA5) begin
      p = int'(a) & 'h1FFF;
      while (1) begin
        b = svis('h100 + (p >> 5)); c = bcrc(c, b);
        if (n < 256) expb[n] = b; n++;
        if (n < 255) begin expb[n] = ~c[7:0]; expb[n+1] = ~c[15:8]; end
        n += 2; c = 16'h0;
        do begin
          b = dmem(p); c = bcrc(c, b);
          if (n < 256) expb[n] = b; n++;
          p++;
        end while (p % 32 != 0);
        if (n < 255) begin expb[n] = ~c[7:0]; expb[n+1] = ~c[15:8]; end
        n += 2; c = 16'h0;
        if (p >= 'h2000) break;
      end
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0; slot_req = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    in_valid = 1'b1; in_byte = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] b, output bit ok);
    ok = 1'b1;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      int w = 0;
      while (!slot_ready && w < 100) begin @(negedge clk); w++; end
      if (w >= 100) ok = 1'b0;
      slot_req = 1'b1;
      @(negedge clk);
      slot_req = 1'b0;
      if (!bit_valid) ok = 1'b0;
      b[i] = bit_out;
    end
  endtask

  function automatic string tagof(input logic [7:0] c);
    case (c)
      8'hF0:   return "R3/R4/R5";
      8'hAA:   return "R3/R6/R7";
      8'hA5:   return "R3/R8/R9";
      default: return "R10";
    endcase
  endfunction

  localparam int NV = 9;
  localparam logic [31:0] VEC [0:NV-1] = '{
    {8'hF0, 16'h1FF8, 8'd12},
    {8'hF0, 16'hFFFC, 8'd7},
    {8'hAA, 16'h0005, 8'd15},
    {8'hAA, 16'h005E, 8'd14},
    {8'hAA, 16'h01FC, 8'd8},
    {8'hA5, 16'h00A3, 8'd40},
    {8'hA5, 16'h1FFC, 8'd11},
    {8'h3C, 16'h0000, 8'd2},
    {8'hAA, 16'h0300, 8'd11}
  };

  initial begin
    logic [7:0] b;
    bit ok;
    int s0, s1, t0;

    do_reset();
    // R1: idle after reset
    check(!slot_ready && !bit_valid && !mem_req, "R1", {13'd0, slot_ready, bit_valid, mem_req}, 16'h0000);

    // R2: slot request while not ready is dropped
    slot_req = 1'b1;
    @(negedge clk);
    slot_req = 1'b0;
    check(!bit_valid, "R2", {15'd0, bit_valid}, 16'h0000);
    build(8'hF0, 16'h1FFE);
    send_byte(8'hF0); send_byte(8'hFE); send_byte(8'h1F);
    read_byte(b, ok);
    check(ok && b == expb[0], "R2", {8'h00, b}, {8'h00, expb[0]});

    for (int v = 0; v < NV; v++) begin
      logic [7:0] cm;
      logic [15:0] ad;
      logic [7:0] nb;
      {cm, ad, nb} = VEC[v];
      do_reset();
      build(cm, ad);
      send_byte(cm); send_byte(ad[7:0]); send_byte(ad[15:8]);
      for (int k = 0; k < int'(nb); k++) begin
        read_byte(b, ok);
        check(ok && b == expb[k], tagof(cm), {8'h00, b}, {8'h00, expb[k]});
      end
    end

    // R11: late input byte ignored mid-stream
    do_reset();
    build(8'hF0, 16'h1FF8);
    send_byte(8'hF0); send_byte(8'hF8); send_byte(8'h1F);
    for (int k = 0; k < 3; k++) begin
      read_byte(b, ok);
      check(ok && b == expb[k], "R11", {8'h00, b}, {8'h00, expb[k]});
    end
    send_byte(8'h55);
    for (int k = 3; k < 12; k++) begin
      read_byte(b, ok);
      check(ok && b == expb[k], "R11", {8'h00, b}, {8'h00, expb[k]});
    end

    // R5 / R12: fetch count, no status fetch, ones without fetches
    do_reset();
    build(8'hF0, 16'h1FFE);
    s0 = nstat; t0 = nreq;
    send_byte(8'hF0); send_byte(8'hFE); send_byte(8'h1F);
    for (int k = 0; k < 4; k++) begin
      read_byte(b, ok);
      check(ok && b == expb[k], "R4", {8'h00, b}, {8'h00, expb[k]});
    end
    check(nreq - t0 == 2, "R12", 16'(nreq - t0), 16'd2);
    check(nstat == s0, "R12", 16'(nstat - s0), 16'd0);
    s1 = nreq;
    for (int k = 0; k < 3; k++) begin
      read_byte(b, ok);
      check(ok && b == 8'hFF, "R5", {8'h00, b}, 16'h00FF);
    end
    check(nreq == s1, "R5", 16'(nreq - s1), 16'd0);

    // R7: never a fetch of an unimplemented status location
    check(badreq == 0, "R7", 16'(badreq), 16'd0);

    summary();
    $finish;
  end

endmodule